// File: doc/BRIEF.md
# Six-Output GF(2^8) Dot-Product Engine

This block produces six parity streams for erasure coding. Each parity byte is a dot product over GF(2^8) of the byte at the same position in every source vector with a coefficient that depends on both the source and the parity output. Multiplication by a coefficient uses a precomputed 32-byte table held in an internal RAM. The low nibble of the source byte indexes the first half of the table and the high nibble indexes the second half. The two looked-up bytes are XORed to form the product.

The host first loads the tables through a byte write port. It then issues a start command with a byte length and a source count. For each 16-byte position the block takes one chunk per source, in source order, and folds it into six accumulators. It then offers the six 16-byte results together with the byte offset they belong to. When the length is not a multiple of 16, one final pass at offset `len-16` covers the tail. That pass overlaps bytes already produced and regenerates them with identical values. The operation ends with a one-cycle done pulse that carries a pass or fail status.

Top module: `gf6_dot_engine`

## Requirements
- R1: Each result byte equals the XOR over all sources i of `T[lo] ^ T[16+hi]`, where T is the 32-byte table for that output and source, and lo/hi are bits 3:0 and 7:4 of the source byte.
- R2: The table for output j (0..5) and source i starts at byte address `(j*vec + i)*32`. Within a table, bytes 0..15 hold the coefficient times 0x00..0x0F and bytes 16..31 hold the coefficient times 0x00, 0x10, .., 0xF0.
- R3: All 16 byte lanes of a chunk (lane b at data bits `8*b+7:8*b`) use the same tables.
- R4: The six accumulators are cleared at the start of each position, so every result depends only on the chunks of its own position.
- R5: Within a position, sources are consumed in index order 0..vec-1, one chunk per `src_valid && src_ready` cycle. The results are offered in the cycle after the last chunk is taken.
- R6: A start with length below 16 produces no output and gives a done pulse with `done_fail` = 1 in the next cycle.
- R7: A start with a source count of 0 or above `MAX_SRC` also fails at once with no output.
- R8: For a length that is a multiple of 16, results come out at offsets 0, 16, .., len-16, and then done is pulsed with `done_fail` = 0.
- R9: For any other length of 16 or more, one extra result follows the last full chunk at offset len-16, and then done is pulsed with `done_fail` = 0.
- R10: Table writes are ignored while `busy` is high.
- R11: `busy` rises in the cycle after an accepted start and stays high through the done cycle. Done lasts one cycle and `busy` is low after it.
- R12: While `out_valid` is high and `out_ready` is low, the results and offset hold stable. `src_ready` stays low whenever `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_we | input | 1 | Table byte write strobe |
| tbl_addr | input | TADDR_W | Table byte address |
| tbl_wdata | input | 8 | Table byte value |
| start | input | 1 | Start command (taken only when idle) |
| start_len | input | LEN_W | Length in bytes |
| start_vec | input | VEC_W | Number of sources |
| busy | output | 1 | Operation in progress |
| src_valid | input | 1 | Source chunk present |
| src_data | input | 128 | Source chunk, lane b at bits 8b+7:8b |
| src_ready | output | 1 | Source chunk accepted this cycle if valid |
| out_valid | output | 1 | Six results offered |
| out_ready | input | 1 | Consumer takes results |
| out_data | output | 768 | Result j at bits 128j+127:128j |
| out_offset | output | LEN_W | Byte offset of the offered results |
| done | output | 1 | One-cycle end-of-operation pulse |
| done_fail | output | 1 | Status with done: 1 fail, 0 pass |

## Verification
A wrong table index or a bad nibble split corrupts the bytes of the affected output lane. This shows on `out_data` in the first result of the operation, one cycle after the last source chunk. A stale accumulator leaves the first position correct but spoils the second result, so every test runs two or more positions. A sequencer fault shows up in a few ways. It can give a wrong or missing tail offset, an extra result, or a done pulse in the wrong cycle. Each of these is visible at the handshake that follows the previous result.

// File: rtl/gf6_pkg.sv
package gf6_pkg;
  localparam int NOUT    = 6;
  localparam int LANES   = 16;
  localparam int CHUNK_W = LANES * 8;
  localparam int TBL_B   = 32;
  localparam int TBL_W   = TBL_B * 8;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_EMIT, ST_DONE} gf6_state_e;

  // product of one byte with the coefficient encoded in tbl (split-nibble form)
  function automatic logic [7:0] split_mul(input logic [TBL_W-1:0] tbl,
                                           input logic [7:0] b);
    int lo;
    int hi;
    lo = int'(b[3:0]);
    hi = int'(b[7:4]);
    return tbl[lo*8 +: 8] ^ tbl[(16 + hi)*8 +: 8];
  endfunction
endpackage

// File: rtl/gf6_table_ram.sv
module gf6_table_ram
  import gf6_pkg::*;
#(
  parameter int MAX_SRC = 16,
  parameter int VEC_W   = 5,
  parameter int TADDR_W = 12
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [TADDR_W-1:0]       wr_addr,
  input  logic [7:0]               wr_byte,
  input  logic [VEC_W-1:0]         rd_vec,
  input  logic [VEC_W-1:0]         rd_src,
  output logic [NOUT*TBL_W-1:0]    rd_tables
);
  localparam int ENTRIES = NOUT * MAX_SRC;
  localparam int IDX_W   = $clog2(ENTRIES);

  logic [TBL_W-1:0] mem [ENTRIES];
  logic [TADDR_W-6:0] wr_entry;

  assign wr_entry = wr_addr[TADDR_W-1:5];

  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_entry) < ENTRIES))
      mem[wr_entry[IDX_W-1:0]][{wr_addr[4:0], 3'b000} +: 8] <= wr_byte;
  end

  for (genvar j = 0; j < NOUT; j++) begin : g_rd
    logic [IDX_W-1:0] idx;
    always_comb begin
      int t;
      t = j * int'(rd_vec) + int'(rd_src);
      idx = (t < ENTRIES) ? IDX_W'(t) : '0;
    end
    assign rd_tables[j*TBL_W +: TBL_W] = mem[idx];
  end
endmodule

// File: rtl/gf6_lane_mac.sv
module gf6_lane_mac
  import gf6_pkg::*;
(
  input  logic [TBL_W-1:0]   tbl,
  input  logic [CHUNK_W-1:0] chunk,
  output logic [CHUNK_W-1:0] prod
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign prod[l*8 +: 8] = split_mul(tbl, chunk[l*8 +: 8]);
  end
endmodule

// File: rtl/gf6_ctrl.sv
module gf6_ctrl
  import gf6_pkg::*;
#(
  parameter int MAX_SRC = 16,
  parameter int LEN_W   = 16,
  parameter int VEC_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] start_len,
  input  logic [VEC_W-1:0] start_vec,
  input  logic             src_valid,
  input  logic             out_ready,
  output logic             busy,
  output logic             src_ready,
  output logic             out_valid,
  output logic             done,
  output logic             fail_q,
  output logic [LEN_W-1:0] pos_q,
  output logic [LEN_W-1:0] op_len_q,
  output logic [VEC_W-1:0] vec_q,
  output logic [VEC_W-1:0] src_idx_q,
  output logic             src_fire,
  output logic             last_src,
  output logic             acc_clear
);
  gf6_state_e state_q;
  logic           start_take, start_bad, start_ok, out_fire, at_end, more_full;
  logic [LEN_W:0] next_pos;
  logic [LEN_W-1:0] tail_base;

  always_comb begin
    start_take = start && (state_q == ST_IDLE);
    start_bad  = start_take && ((start_len < LEN_W'(16)) || (start_vec == '0) ||
                                (start_vec > VEC_W'(MAX_SRC)));
    start_ok   = start_take && !start_bad;
    busy       = state_q != ST_IDLE;
    src_ready  = state_q == ST_RUN;
    out_valid  = state_q == ST_EMIT;
    done       = state_q == ST_DONE;
    src_fire   = src_ready && src_valid;
    last_src   = src_idx_q == (vec_q - VEC_W'(1));
    out_fire   = out_valid && out_ready;
    next_pos   = {1'b0, pos_q} + (LEN_W+1)'(16);
    tail_base  = op_len_q - LEN_W'(16);
    at_end     = next_pos == {1'b0, op_len_q};
    more_full  = next_pos <= {1'b0, tail_base};
    acc_clear  = start_ok || (out_fire && !at_end);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      fail_q    <= 1'b0;
      pos_q     <= '0;
      op_len_q  <= '0;
      vec_q     <= '0;
      src_idx_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_ok) begin
            state_q   <= ST_RUN;
            fail_q    <= 1'b0;
            op_len_q  <= start_len;
            vec_q     <= start_vec;
            pos_q     <= '0;
            src_idx_q <= '0;
          end else if (start_bad) begin
            state_q <= ST_DONE;
            fail_q  <= 1'b1;
          end
        end
        ST_RUN: begin
          if (src_fire) begin
            if (last_src) begin
              state_q   <= ST_EMIT;
              src_idx_q <= '0;
            end else begin
              src_idx_q <= src_idx_q + VEC_W'(1);
            end
          end
        end
        ST_EMIT: begin
          if (out_fire) begin
            if (at_end) state_q <= ST_DONE;
            else begin
              state_q <= ST_RUN;
              pos_q   <= more_full ? next_pos[LEN_W-1:0] : tail_base;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gf6_dot_engine.sv
module gf6_dot_engine
  import gf6_pkg::*;
#(
  parameter  int MAX_SRC = 16,
  parameter  int LEN_W   = 16,
  localparam int VEC_W   = $clog2(MAX_SRC + 1),
  localparam int TADDR_W = $clog2(NOUT * MAX_SRC * TBL_B)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tbl_we,
  input  logic [TADDR_W-1:0]      tbl_addr,
  input  logic [7:0]              tbl_wdata,
  input  logic                    start,
  input  logic [LEN_W-1:0]        start_len,
  input  logic [VEC_W-1:0]        start_vec,
  output logic                    busy,
  input  logic                    src_valid,
  input  logic [CHUNK_W-1:0]      src_data,
  output logic                    src_ready,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [NOUT*CHUNK_W-1:0] out_data,
  output logic [LEN_W-1:0]        out_offset,
  output logic                    done,
  output logic                    done_fail
);
  logic                     fail_q, src_fire, last_src, acc_clear, tbl_wr_en;
  logic [LEN_W-1:0]         pos_q, op_len_q;
  logic [VEC_W-1:0]         vec_q, src_idx_q;
  logic [NOUT*TBL_W-1:0]    tables;
  logic [NOUT-1:0][CHUNK_W-1:0] prod, acc_q;

  gf6_ctrl #(.MAX_SRC(MAX_SRC), .LEN_W(LEN_W), .VEC_W(VEC_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .start_len(start_len),
    .start_vec(start_vec), .src_valid(src_valid), .out_ready(out_ready),
    .busy(busy), .src_ready(src_ready), .out_valid(out_valid), .done(done),
    .fail_q(fail_q), .pos_q(pos_q), .op_len_q(op_len_q), .vec_q(vec_q),
    .src_idx_q(src_idx_q), .src_fire(src_fire), .last_src(last_src),
    .acc_clear(acc_clear)
  );

  assign tbl_wr_en = tbl_we && !busy;

  gf6_table_ram #(.MAX_SRC(MAX_SRC), .VEC_W(VEC_W), .TADDR_W(TADDR_W)) u_ram (
    .clk(clk), .wr_en(tbl_wr_en), .wr_addr(tbl_addr), .wr_byte(tbl_wdata),
    .rd_vec(vec_q), .rd_src(src_idx_q), .rd_tables(tables)
  );

  for (genvar j = 0; j < NOUT; j++) begin : g_out
    gf6_lane_mac u_mac (
      .tbl(tables[j*TBL_W +: TBL_W]), .chunk(src_data), .prod(prod[j])
    );
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         acc_q[j] <= '0;
      else if (acc_clear) acc_q[j] <= '0;
      else if (src_fire)  acc_q[j] <= acc_q[j] ^ prod[j];
    end
    assign out_data[j*CHUNK_W +: CHUNK_W] = acc_q[j];
  end

  assign out_offset = pos_q;
  assign done_fail  = done && fail_q;
endmodule

// File: rtl/gf6_dot_checker.sv
module gf6_dot_checker #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [LEN_W-1:0] start_len,
  input logic             busy,
  input logic             src_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [767:0]     out_data,
  input logic [LEN_W-1:0] out_offset,
  input logic [LEN_W-1:0] op_len_q,
  input logic             done,
  input logic             done_fail,
  input logic             tbl_wr_en,
  input logic             src_fire,
  input logic             last_src
);
  a_r6_short_fails: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && (start_len < LEN_W'(16)) |=> done && done_fail);

  a_r12_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_offset));

  a_r12_no_intake: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_ready && out_valid));

  a_r9_offset_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((LEN_W+1)'(out_offset) + (LEN_W+1)'(16) <= (LEN_W+1)'(op_len_q)));

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy && !done);

  a_r10_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !tbl_wr_en);

  a_r5_last_emits: assert property (@(posedge clk) disable iff (!rst_n)
    src_fire && last_src |=> out_valid);
endmodule

bind gf6_dot_engine gf6_dot_checker #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_len(start_len), .busy(busy),
  .src_ready(src_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_offset(out_offset), .op_len_q(op_len_q),
  .done(done), .done_fail(done_fail), .tbl_wr_en(tbl_wr_en),
  .src_fire(src_fire), .last_src(last_src)
);

// File: tb/gf6_dot_engine_bench.sv
module gf6_dot_engine_bench;
  localparam int MAX_SRC = 16;
  localparam int LEN_W   = 16;
  localparam int VEC_W   = $clog2(MAX_SRC + 1);
  localparam int TADDR_W = $clog2(6 * MAX_SRC * 32);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tbl_we = 1'b0;
  logic [TADDR_W-1:0] tbl_addr = '0;
  logic [7:0] tbl_wdata = '0;
  logic start = 1'b0;
  logic [LEN_W-1:0] start_len = '0;
  logic [VEC_W-1:0] start_vec = '0;
  logic busy, src_ready, out_valid, done, done_fail;
  logic src_valid = 1'b0;
  logic [127:0] src_data = '0;
  logic out_ready = 1'b0;
  logic [767:0] out_data;
  logic [LEN_W-1:0] out_offset;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  gf6_dot_engine #(.MAX_SRC(MAX_SRC), .LEN_W(LEN_W)) u_gf6_dot_engine (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .start(start), .start_len(start_len),
    .start_vec(start_vec), .busy(busy), .src_valid(src_valid),
    .src_data(src_data), .src_ready(src_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_offset(out_offset),
    .done(done), .done_fail(done_fail)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      checks = checks + 1;
      fails = fails + 1;
      $display("FAIL R11 watchdog: actual no finish, expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  // plain shift-and-add multiply, polynomial x^8+x^4+x^3+x^2+1
  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 8'h00;
    logic [7:0] x = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) r = r ^ x;
      x = x[7] ? ((x << 1) ^ 8'h1D) : (x << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] coef(input int j, input int i, input int seed);
    return 8'((j * 41 + i * 13 + seed * 17 + 7) & 255);
  endfunction

  function automatic logic [7:0] sbyte(input int i, input int p);
    return 8'((i * 53 + p * 7 + (p >> 3) * 29 + 3) & 255);
  endfunction

  function automatic logic [127:0] exp_chunk(input int j, input int vec,
                                              input int seed, input int off);
    logic [127:0] r = '0;
    for (int b = 0; b < 16; b++)
      for (int i = 0; i < vec; i++)
        r[b*8 +: 8] = r[b*8 +: 8] ^ gmul(coef(j, i, seed), sbyte(i, off + b));
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic load_tables(input int vec, input int seed);
    @(negedge clk);
    for (int j = 0; j < 6; j++)
      for (int i = 0; i < vec; i++)
        for (int b = 0; b < 32; b++) begin
          tbl_we    = 1'b1;
          tbl_addr  = TADDR_W'((j * vec + i) * 32 + b);
          tbl_wdata = (b < 16) ? gmul(coef(j, i, seed), 8'(b))
                               : gmul(coef(j, i, seed), 8'((b - 16) << 4));
          @(negedge clk);
        end
    tbl_we = 1'b0;
  endtask

  // full operation: R1-type data checks per output, offsets, status
  task automatic run_op(input int len, input int vec, input int seed,
                        input bit stall, input bit poke, input string req);
    int off = 0;
    start = 1'b1; start_len = LEN_W'(len); start_vec = VEC_W'(vec);
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R11", "busy after start", 128'(busy), 128'd1);
    if (poke) begin
      tbl_we = 1'b1; tbl_addr = '0; tbl_wdata = 8'hA5;
      @(negedge clk);
      tbl_we = 1'b0; tbl_addr = TADDR_W'(32 + 17); tbl_wdata = 8'h3C;
      tbl_we = 1'b1;
      @(negedge clk);
      tbl_we = 1'b0;
    end
    forever begin
      for (int i = 0; i < vec; i++) begin
        src_valid = 1'b1;
        for (int b = 0; b < 16; b++) src_data[b*8 +: 8] = sbyte(i, off + b);
        while (src_ready !== 1'b1) @(negedge clk);
        @(negedge clk);
      end
      src_valid = 1'b0;
      chk(out_valid === 1'b1, "R5", "out_valid after last source", 128'(out_valid), 128'd1);
      if (stall) begin
        logic [767:0] snap = out_data;
        for (int s = 0; s < 3; s++) begin
          @(negedge clk);
          chk(out_valid === 1'b1 && out_data === snap && src_ready === 1'b0,
              "R12", "hold under backpressure", out_data[127:0], snap[127:0]);
        end
      end
      chk(out_offset === LEN_W'(off), req, "offset", 128'(out_offset), 128'(off));
      for (int j = 0; j < 6; j++) begin
        logic [127:0] e = exp_chunk(j, vec, seed, off);
        chk(out_data[j*128 +: 128] === e, req, $sformatf("R1 output %0d off %0d", j, off),
            out_data[j*128 +: 128], e);
      end
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      if (off + 16 == len) break;
      off = (off + 32 <= len) ? off + 16 : len - 16;
    end
    chk(done === 1'b1 && done_fail === 1'b0, req, "pass status",
        128'({done, done_fail}), 128'b10);
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R11", "idle after done",
        128'({busy, done}), 128'b00);
  endtask

  task automatic fail_op(input int len, input int vec, input string req);
    start = 1'b1; start_len = LEN_W'(len); start_vec = VEC_W'(vec);
    @(negedge clk);
    start = 1'b0;
    chk(done === 1'b1 && done_fail === 1'b1 && out_valid === 1'b0, req,
        $sformatf("fail status len %0d vec %0d", len, vec),
        128'({done, done_fail, out_valid}), 128'b110);
    @(negedge clk);
    chk(busy === 1'b0 && out_valid === 1'b0, req, "idle after fail",
        128'({busy, out_valid}), 128'b00);
  endtask

  task automatic test_reset();
    chk(busy === 1'b0 && out_valid === 1'b0 && src_ready === 1'b0 && done === 1'b0,
        "R11", "reset state", 128'({busy, out_valid, src_ready, done}), 128'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    // R1 R3 R4 R5 R8: two full positions, three sources
    load_tables(3, 1);
    run_op(32, 3, 1, 1'b0, 1'b0, "R8");
    // R9: length 40 gives offsets 0, 16, 24
    run_op(40, 3, 1, 1'b0, 1'b0, "R9");
    // R12: single source with backpressure, R9 tail at offset 1
    load_tables(1, 2);
    run_op(17, 1, 2, 1'b1, 1'b0, "R9");
    // R2: maximum source count, table layout j*vec+i
    load_tables(16, 3);
    run_op(20, 16, 3, 1'b0, 1'b0, "R2");
    // R10: table writes during busy must not change results
    load_tables(2, 4);
    run_op(48, 2, 4, 1'b1, 1'b1, "R10");
    // R6 and R7
    fail_op(15, 2, "R6");
    fail_op(0, 3, "R6");
    fail_op(64, 0, "R7");
    fail_op(64, MAX_SRC + 1, "R7");
    // after the refused starts the tables still give the R10 results
    run_op(32, 2, 4, 1'b0, 1'b0, "R4");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule